// File: doc/BRIEF.md
# Processor Sleep Entry Sequencer

This block steps the processor clock-stop and CPU-sleep lines through entry to a system sleep state and back out again. The power manager presents a request code with a one-cycle valid strobe. A legal request moves the block out of its running state. The stop-clock line is then held asserted while the block waits for the first stop-grant acknowledge pulse. When the sleep-enable bit was set at request time, the block counts a fixed number of bus clocks from that first pulse and then asserts CPU-sleep. It then raises a done flag, which the power sequencer uses as permission to remove processor power. With the enable bit clear, done is raised as soon as the first acknowledge arrives, and CPU-sleep is never driven.

One stop-clock line serves both processors of a two-socket system. Acknowledges that arrive after the first one play no part in the timing. The deep states S3, S4 and S5 take exactly the same entry path as S1. A request for S2 is dropped, and so is any code that does not name a state. While the block is running, an overheat input makes it pulse stop-clock with a duty cycle set by an input: so many asserted clocks out of every period. An active sleep sequence overrides this throttling and holds the line solid. A wake strobe releases CPU-sleep first and releases stop-clock one clock later.

Both outputs model open-drain pull-down enables: 1 pulls the active-low line low, and 0 leaves it floating, so it reads as 1.

FSM states: RUN (idle, throttling allowed), STOPWAIT (stop-clock held, waiting for the first acknowledge), DELAY (counting bus clocks), SLEEP (entry complete, done high), WAKE (CPU-sleep released, stop-clock still held). Transitions: RUN→STOPWAIT on a legal request; STOPWAIT→DELAY on the first acknowledge with enable set; STOPWAIT→SLEEP on the first acknowledge with enable clear; DELAY→SLEEP when the count expires; STOPWAIT/DELAY/SLEEP→WAKE on wake; WAKE→RUN unconditionally.

Top module: `cpu_sleep_seq`

## Requirements
- R1: A synchronous active-high reset leaves both pull enables at 0, done at 0 and the block in RUN. With overheat low, stop-clock then stays released.
- R2: A request strobe in RUN with code 1 (S1), 3 (S3), 4 (S4) or 5 (S5) asserts the stop-clock pull on the clock edge that samples it. The pull is then held until wake.
- R3: Request code 2 (S2), and codes 0, 6 and 7, are ignored: stop-clock stays released and the block stays in RUN.
- R4: With sleep-enable 1 at the request, the CPU-sleep pull rises on the 8th rising edge after the edge that samples the first acknowledge pulse. It is not asserted before that edge.
- R5: Acknowledge pulses after the first one do not restart or shorten the 8-clock delay.
- R6: With sleep-enable 0 at the request, CPU-sleep is never asserted, and done rises on the edge that samples the first acknowledge.
- R7: Done rises together with CPU-sleep when enabled. Done is only ever high while stop-clock is held.
- R8: In RUN with overheat high, stop-clock is asserted for exactly `thr_duty` clocks in every 8-clock window (period parameter 8).
- R9: During a sleep sequence, stop-clock stays asserted on every cycle regardless of overheat and duty.
- R10: A wake strobe drops CPU-sleep and done on the edge that samples it while stop-clock stays held. Stop-clock is released one edge later, and a new request is then accepted.
- R11: Acknowledge pulses while in RUN have no effect: a later request still waits for a fresh acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle sleep request strobe |
| req_code | input | 3 | Requested state code (1,3,4,5 legal) |
| slp_en | input | 1 | Sleep-enable bit, latched with the request |
| ack_pulse | input | 1 | One pulse per stop-grant acknowledge cycle |
| overheat | input | 1 | Thermal overheat, enables throttling |
| thr_duty | input | DUTY_W | Asserted clocks per throttle period |
| wake | input | 1 | Wake strobe, starts exit |
| stpclk_pull | output | 1 | Pull-down enable for stop-clock line |
| cpuslp_pull | output | 1 | Pull-down enable for CPU-sleep line |
| done | output | 1 | Entry complete, power may be removed |

## Verification
The bench times CPU-sleep against the first acknowledge on both sides of the 8-clock edge. An off-by-one counter would show the line one clock early or late. A second acknowledge sent in mid-count would expose a design that restarts the delay, because its CPU-sleep would then come late. It sweeps every request code, so a design that accepts S2 or an undefined code would hold stop-clock when it should not, and throttle windows with zero, partial and full duty catch a wrong comparison. Wake ordering is checked cycle by cycle, which reveals a design that drops both lines together.

// File: rtl/cpu_sleep_pkg.sv
package cpu_sleep_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STOPWAIT = 3'd1,
        ST_DELAY    = 3'd2,
        ST_SLEEP    = 3'd3,
        ST_WAKE     = 3'd4
    } seq_state_t;

    localparam int REQ_W = 3;

    localparam logic [REQ_W-1:0] CODE_S1 = 3'd1;
    localparam logic [REQ_W-1:0] CODE_S2 = 3'd2;
    localparam logic [REQ_W-1:0] CODE_S3 = 3'd3;
    localparam logic [REQ_W-1:0] CODE_S4 = 3'd4;
    localparam logic [REQ_W-1:0] CODE_S5 = 3'd5;

endpackage

// File: rtl/sleep_req_filter.sv
module sleep_req_filter
    import cpu_sleep_pkg::*;
(
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_code,
    output logic             req_ok
);
    // S2 is unsupported; deep states share the light-sleep path
    always_comb begin
        unique case (req_code)
            CODE_S1, CODE_S3, CODE_S4, CODE_S5: req_ok = req_valid;
            default:                            req_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sleep_delay_cnt.sv
module sleep_delay_cnt #(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(DELAY) + 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/throttle_gen.sv
module throttle_gen #(
    parameter int PERIOD = 8,
    localparam int TW = $clog2(PERIOD),
    localparam int DW = TW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] duty,
    output logic          on
);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !en)      phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                 phase <= phase + 1'b1;
    end

    assign on = en && ({1'b0, phase} < duty);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import cpu_sleep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_ok,
    input  logic slp_en,
    input  logic ack_pulse,
    input  logic wake,
    input  logic dly_expired,
    input  logic thr_on,
    output logic dly_run,
    output logic in_run,
    output logic stpclk_pull,
    output logic cpuslp_pull,
    output logic done
);
    seq_state_t state, nxt;
    logic       en_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (req_ok) nxt = ST_STOPWAIT;
            ST_STOPWAIT: if (wake) nxt = ST_WAKE;
                         else if (ack_pulse) nxt = en_q ? ST_DELAY : ST_SLEEP;
            ST_DELAY:    if (wake) nxt = ST_WAKE;
                         else if (dly_expired) nxt = ST_SLEEP;
            ST_SLEEP:    if (wake) nxt = ST_WAKE;
            ST_WAKE:     nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && req_ok) en_q <= slp_en;
        end
    end

    always_comb begin
        in_run      = (state == ST_RUN);
        dly_run     = (state == ST_DELAY);
        stpclk_pull = in_run ? thr_on : 1'b1;
        cpuslp_pull = (state == ST_SLEEP) && en_q;
        done        = (state == ST_SLEEP);
    end
endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq
    import cpu_sleep_pkg::*;
#(
    parameter int SLP_DELAY  = 8,
    parameter int THR_PERIOD = 8,
    localparam int DUTY_W = $clog2(THR_PERIOD) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [REQ_W-1:0]  req_code,
    input  logic              slp_en,
    input  logic              ack_pulse,
    input  logic              overheat,
    input  logic [DUTY_W-1:0] thr_duty,
    input  logic              wake,
    output logic              stpclk_pull,
    output logic              cpuslp_pull,
    output logic              done
);
    logic req_ok, dly_run, dly_expired, in_run, thr_on;

    sleep_req_filter u_filt (
        .req_valid (req_valid),
        .req_code  (req_code),
        .req_ok    (req_ok)
    );

    sleep_delay_cnt #(.DELAY(SLP_DELAY)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .run     (dly_run),
        .expired (dly_expired)
    );

    throttle_gen #(.PERIOD(THR_PERIOD)) u_thr (
        .clk  (clk),
        .rst  (rst),
        .en   (overheat && in_run),
        .duty (thr_duty),
        .on   (thr_on)
    );

    sleep_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_ok      (req_ok),
        .slp_en      (slp_en),
        .ack_pulse   (ack_pulse),
        .wake        (wake),
        .dly_expired (dly_expired),
        .thr_on      (thr_on),
        .dly_run     (dly_run),
        .in_run      (in_run),
        .stpclk_pull (stpclk_pull),
        .cpuslp_pull (cpuslp_pull),
        .done        (done)
    );
endmodule

// File: rtl/cpu_sleep_chk.sv
module cpu_sleep_chk (
    input logic clk,
    input logic rst,
    input logic stpclk_pull,
    input logic cpuslp_pull,
    input logic done
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cpuslp_pull && !done));

    // R4
    slp_under_stop_chk: assert property (@(posedge clk) disable iff (rst)
        cpuslp_pull |-> stpclk_pull);

    // R7
    slp_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpuslp_pull) |-> done);

    // R7
    done_under_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> stpclk_pull);

    // R10
    wake_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpuslp_pull) |-> stpclk_pull);

    // R10
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> (!cpuslp_pull && stpclk_pull));
endmodule

bind cpu_sleep_seq cpu_sleep_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .stpclk_pull (stpclk_pull),
    .cpuslp_pull (cpuslp_pull),
    .done        (done)
);

// File: tb/cpu_sleep_seq_tb.sv
module cpu_sleep_seq_tb;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_code = 3'd0;
    logic slp_en = 1'b0;
    logic ack_pulse = 1'b0;
    logic overheat = 1'b0;
    logic [DW-1:0] thr_duty = '0;
    logic wake = 1'b0;
    logic stpclk_pull, cpuslp_pull, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cpu_sleep_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .slp_en(slp_en), .ack_pulse(ack_pulse), .overheat(overheat),
        .thr_duty(thr_duty), .wake(wake), .stpclk_pull(stpclk_pull),
        .cpuslp_pull(cpuslp_pull), .done(done)
    );

    // {accept, code}
    localparam logic [3:0] REQ_TAB [8] = '{
        4'b0_000, 4'b1_001, 4'b0_010, 4'b1_011,
        4'b1_100, 4'b1_101, 4'b0_110, 4'b0_111
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; ack_pulse = 1'b0; wake = 1'b0;
        overheat = 1'b0; thr_duty = '0; slp_en = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic request(input logic [2:0] code, input logic en);
        req_valid = 1'b1; req_code = code; slp_en = en;
        cyc(1);
        req_valid = 1'b0; slp_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_pulse = 1'b1;
        cyc(1);
        ack_pulse = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1 reset state
        do_reset();
        chk("R1 stpclk", stpclk_pull, 0);
        chk("R1 cpuslp", cpuslp_pull, 0);
        chk("R1 done", done, 0);

        // R2 / R3 table of request codes
        for (int k = 0; k < 8; k++) begin
            do_reset();
            request(REQ_TAB[k][2:0], 1'b1);
            chk(REQ_TAB[k][3] ? "R2 accept" : "R3 reject", stpclk_pull, int'(REQ_TAB[k][3]));
            cyc(3);
            chk(REQ_TAB[k][3] ? "R2 hold" : "R3 still idle", stpclk_pull, int'(REQ_TAB[k][3]));
        end

        // R4 delay edge, R5 second ack mid-count
        do_reset();
        request(3'd1, 1'b1);
        pulse_ack();           // now at N1
        cyc(2);
        pulse_ack();           // second ack, now at N4
        cyc(4);                // N8
        chk("R4 not early", cpuslp_pull, 0);
        chk("R4 done not early", done, 0);
        cyc(1);                // N9
        chk("R4/R5 cpuslp at 8", cpuslp_pull, 1);
        chk("R7 done with cpuslp", done, 1);
        chk("R9 stop held", stpclk_pull, 1);

        // R10 wake ordering
        wake = 1'b1;
        cyc(1);
        wake = 1'b0;
        chk("R10 cpuslp off", cpuslp_pull, 0);
        chk("R10 done off", done, 0);
        chk("R10 stop still held", stpclk_pull, 1);
        cyc(1);
        chk("R10 stop released", stpclk_pull, 0);
        request(3'd5, 1'b0);
        chk("R10 new request accepted", stpclk_pull, 1);

        // R6 enable clear: done at once, no cpuslp
        pulse_ack();
        chk("R6 done at first ack", done, 1);
        chk("R6 no cpuslp", cpuslp_pull, 0);
        cyc(12);
        chk("R6 cpuslp stays off", cpuslp_pull, 0);

        // R11 ack in RUN ignored
        do_reset();
        pulse_ack();
        cyc(2);
        request(3'd3, 1'b1);
        cyc(12);
        chk("R11 no cpuslp without fresh ack", cpuslp_pull, 0);
        chk("R11 no done", done, 0);

        // R8 throttle duty
        for (int d = 0; d <= 8; d += 4) begin
            do_reset();
            overheat = 1'b1; thr_duty = DW'(d);
            cnt = 0;
            for (int i = 0; i < 8; i++) begin
                cyc(1);
                cnt += int'(stpclk_pull);
            end
            chk("R8 duty count", cnt, (d == 4) ? 4 : d);
        end
        do_reset();
        overheat = 1'b1; thr_duty = DW'(3);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            cnt += int'(stpclk_pull);
        end
        chk("R8 duty 3", cnt, 3);

        // R9 sleep overrides throttle
        thr_duty = DW'(1);
        request(3'd4, 1'b1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            cnt += int'(stpclk_pull);
        end
        chk("R9 solid stop", cnt, 8);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule